// File: doc/BRIEF.md
# Redundant Command Frame Validator

This block watches a byte stream from a byte receiver and looks for one fixed nine-byte command frame that sets two glyph start addresses. The frame is built with redundancy. A constant preamble is followed by the command and its complement. Then comes a one-byte payload M and its complement, then an additive checksum and its complement. Each byte is compared as it arrives. Nothing is buffered. A single mismatch discards the partial frame, and the search starts again at the first preamble byte.

When all nine bytes match and the two top bits of the payload are both set, the block loads two address registers from the payload. The left address comes from the glyph index in M[2:0] and the right address from the glyph index in M[5:3]. Each index is scaled by the rows per glyph. A one-cycle strobe marks the update, and the addresses hold their values until the next accepted frame.

The input is a valid/ready stream. The block never applies back-pressure: `in_ready` is high in every cycle. A byte is therefore consumed on every rising clock edge at which `in_valid` is high. Idle cycles between bytes are allowed and have no effect.

Top module: `cmd_frame_validator`

## Requirements
- R1: After reset, `upd_o` is low and both `left_addr` and `right_addr` are zero.
- R2: `in_ready` is 1 in every cycle, so each cycle with `in_valid` high consumes exactly one byte.
- R3: Bytes 1 to 5 of a frame must be 0x55, 0xFF, 0x00, 0xF7 and 0x08, in that order.
- R4: Byte 6 is the payload M and may take any value. Byte 7 must equal the bitwise inverse of M.
- R5: Byte 8 must equal (M + 0xF7) mod 256.
- R6: Byte 9 must equal the bitwise inverse of (M + 0xF7) mod 256.
- R7: A byte that differs from its expected value abandons the frame, and the next byte is compared against 0x55. The failing byte itself is not taken as a new 0x55 start, even if it equals 0x55.
- R8: A frame whose nine bytes all match is accepted only when M[7] and M[6] are both 1. Otherwise the strobe stays low and the addresses are unchanged.
- R9: On acceptance, `left_addr` = M[2:0] * 8 and `right_addr` = M[5:3] * 8. For example, M = 0xFA gives left 16 and right 56.
- R10: `upd_o` is high for exactly the one cycle that follows the clock edge that consumed byte 9 of an accepted frame. The addresses change at that same edge and at no other time.
- R11: Cycles with `in_valid` low do not advance, reset or otherwise alter frame tracking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Always 1; the block accepts a byte every cycle |
| in_data | input | 8 | Input byte |
| upd_o | output | 1 | One-cycle strobe when the addresses are loaded |
| left_addr | output | 6 | Left glyph start address |
| right_addr | output | 6 | Right glyph start address |

## Verification
The hardest case to reach is the one where the byte that breaks a frame is itself 0x55. It could wrongly be taken as the start of a new frame, and an accepted frame would follow one byte later than it should. The stimulus sends 0x55 twice and then the remainder of an otherwise perfect frame. It then sends a clean frame straight away, so a validator that restarts on the failing byte would show an extra strobe. Bytes arrive both back-to-back and with idle gaps. A behavioural model predicts the strobe and both addresses in every cycle.

// File: rtl/frame_check_pkg.sv
package frame_check_pkg;
  localparam int BYTE_W    = 8;
  localparam int FRAME_LEN = 9;
  localparam int PRE_LEN   = 5;
  localparam int SLOT_W    = $clog2(FRAME_LEN);

  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam slot_t SLOT_PAY   = slot_t'(PRE_LEN);
  localparam slot_t SLOT_PAY_N = slot_t'(PRE_LEN + 1);
  localparam slot_t SLOT_SUM   = slot_t'(PRE_LEN + 2);
  localparam slot_t SLOT_LAST  = slot_t'(FRAME_LEN - 1);
endpackage

// File: rtl/frame_slot_expect.sv
module frame_slot_expect
  import frame_check_pkg::*;
#(
  parameter logic [PRE_LEN-1:0][BYTE_W-1:0] PREAMBLE = '0,
  parameter byte_t SUM_BIAS = 8'hF7
) (
  input  slot_t slot,
  input  byte_t payload,
  output byte_t want,
  output logic  free
);
  byte_t sum;
  assign sum = payload + SUM_BIAS;

  always_comb begin
    free = 1'b0;
    want = '0;
    if (slot < SLOT_PAY) begin
      want = PREAMBLE[PRE_LEN-1-int'(slot)];
    end else if (slot == SLOT_PAY) begin
      free = 1'b1;
    end else if (slot == SLOT_PAY_N) begin
      want = ~payload;
    end else if (slot == SLOT_SUM) begin
      want = sum;
    end else begin
      want = ~sum;
    end
  end
endmodule

// File: rtl/frame_slot_tracker.sv
module frame_slot_tracker
  import frame_check_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  input  byte_t in_data,
  input  byte_t want,
  input  logic  free,
  output slot_t slot,
  output byte_t payload,
  output logic  frame_ok
);
  logic hit;
  assign hit      = free || (in_data == want);
  assign frame_ok = in_valid && hit && (slot == SLOT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot    <= '0;
      payload <= '0;
    end else if (in_valid) begin
      if (free) payload <= in_data;
      if (!hit || slot == SLOT_LAST) slot <= '0;
      else                           slot <= slot + 1'b1;
    end
  end

  // R7: a mismatching byte sends tracking back to the first preamble byte
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !free && in_data != want) |=> slot == '0);
  // R3: a matching byte short of the last one moves to the next slot
  p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (free || in_data == want) && slot != SLOT_LAST)
      |=> slot == $past(slot) + 1'b1);
  // R11: idle cycles leave tracking untouched
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(slot) && $stable(payload)));
  // R4: the stored payload only changes when the payload slot is consumed
  p_payload_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && slot == SLOT_PAY) |=> $stable(payload));
endmodule

// File: rtl/frame_glyph_publish.sv
module frame_glyph_publish
  import frame_check_pkg::*;
#(
  parameter int GLYPH_BITS = 3,
  parameter int ROW_SHIFT  = 3,
  localparam int ADDR_W    = GLYPH_BITS + ROW_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_ok,
  input  byte_t             payload,
  output logic              upd_o,
  output logic [ADDR_W-1:0] left_addr,
  output logic [ADDR_W-1:0] right_addr
);
  logic enabled;
  assign enabled = &payload[BYTE_W-1:BYTE_W-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_o      <= 1'b0;
      left_addr  <= '0;
      right_addr <= '0;
    end else begin
      upd_o <= frame_ok && enabled;
      if (frame_ok && enabled) begin
        left_addr  <= {payload[GLYPH_BITS-1:0], {ROW_SHIFT{1'b0}}};
        right_addr <= {payload[2*GLYPH_BITS-1:GLYPH_BITS], {ROW_SHIFT{1'b0}}};
      end
    end
  end

  // R10: the strobe never lasts two cycles (a frame needs nine bytes)
  p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> !upd_o);
  // R10: addresses move only together with the strobe
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_o |-> ($stable(left_addr) && $stable(right_addr)));
  // R8: a strobe follows only a completed frame
  p_strobe_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> $past(frame_ok));
endmodule

// File: rtl/cmd_frame_validator.sv
module cmd_frame_validator
  import frame_check_pkg::*;
#(
  parameter byte_t HDR_A    = 8'h55,
  parameter byte_t HDR_B    = 8'hFF,
  parameter byte_t HDR_C    = 8'h00,
  parameter byte_t CMD      = 8'hF7,
  parameter int    GLYPH_BITS = 3,
  parameter int    ROW_SHIFT  = 3,
  localparam int   ADDR_W     = GLYPH_BITS + ROW_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              upd_o,
  output logic [ADDR_W-1:0] left_addr,
  output logic [ADDR_W-1:0] right_addr
);
  localparam logic [PRE_LEN-1:0][BYTE_W-1:0] PREAMBLE =
    {HDR_A, HDR_B, HDR_C, CMD, ~CMD};

  slot_t slot;
  byte_t payload;
  byte_t want;
  logic  free;
  logic  frame_ok;

  assign in_ready = 1'b1;

  frame_slot_expect #(.PREAMBLE(PREAMBLE), .SUM_BIAS(CMD)) u_expect (
    .slot    (slot),
    .payload (payload),
    .want    (want),
    .free    (free)
  );

  frame_slot_tracker u_tracker (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .want     (want),
    .free     (free),
    .slot     (slot),
    .payload  (payload),
    .frame_ok (frame_ok)
  );

  frame_glyph_publish #(.GLYPH_BITS(GLYPH_BITS), .ROW_SHIFT(ROW_SHIFT)) u_publish (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_ok   (frame_ok),
    .payload    (payload),
    .upd_o      (upd_o),
    .left_addr  (left_addr),
    .right_addr (right_addr)
  );

  // R9: after a strobe the low row bits of both addresses are clear
  p_row_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> (left_addr[ROW_SHIFT-1:0] == '0 && right_addr[ROW_SHIFT-1:0] == '0));
endmodule

// File: tb/test_cmd_frame_validator.sv
module test_cmd_frame_validator;
  typedef logic [7:0] frame_t [9];

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic       upd_o;
  logic [5:0] left_addr;
  logic [5:0] right_addr;

  int total = 0;
  int bad = 0;
  int strobes = 0;
  bit started = 0;

  always #4 clk = ~clk;

  cmd_frame_validator i_cmd_frame_validator (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .upd_o      (upd_o),
    .left_addr  (left_addr),
    .right_addr (right_addr)
  );

  // behavioural reference
  int         m_idx = 0;
  logic [7:0] m_pay = '0;
  logic       e_upd = 1'b0;
  logic [5:0] e_left = '0;
  logic [5:0] e_right = '0;

  always @(posedge clk) begin
    logic [7:0] exp_b;
    if (!rst_n) begin
      m_idx = 0; m_pay = '0; e_upd = 0; e_left = '0; e_right = '0;
    end else begin
      e_upd = 0;
      if (in_valid) begin
        case (m_idx)
          0: exp_b = 8'h55;
          1: exp_b = 8'hFF;
          2: exp_b = 8'h00;
          3: exp_b = 8'hF7;
          4: exp_b = 8'h08;
          6: exp_b = ~m_pay;
          7: exp_b = m_pay + 8'hF7;
          default: exp_b = ~(m_pay + 8'hF7);
        endcase
        if (m_idx == 5) begin
          m_pay = in_data;
          m_idx = 6;
        end else if (in_data == exp_b) begin
          if (m_idx == 8) begin
            m_idx = 0;
            if (m_pay[7] && m_pay[6]) begin
              e_upd = 1;
              e_left = m_pay[2:0] * 8;
              e_right = m_pay[5:3] * 8;
            end
          end else m_idx = m_idx + 1;
        end else m_idx = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk(upd_o == e_upd, "R10 strobe vs model", upd_o, e_upd);
      chk(left_addr == e_left, "R9 left vs model", left_addr, e_left);
      chk(right_addr == e_right, "R9 right vs model", right_addr, e_right);
      chk(in_ready == 1'b1, "R2 ready", in_ready, 1);
      if (upd_o) strobes++;
    end
  end

  function automatic frame_t mk(input logic [7:0] m);
    frame_t f;
    f = '{8'h55, 8'hFF, 8'h00, 8'hF7, 8'h08, m, ~m, m + 8'hF7, ~(m + 8'hF7)};
    return f;
  endfunction

  task automatic send_byte(input logic [7:0] b, input int gap);
    in_valid = 1'b1;
    in_data = b;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_frame(input frame_t f, input int gap);
    foreach (f[i]) send_byte(f[i], gap);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_state(input string req, input int n_str, input int l, input int r);
    chk(strobes == n_str, {req, " strobe count"}, strobes, n_str);
    chk(left_addr == 6'(l), {req, " left"}, left_addr, l);
    chk(right_addr == 6'(r), {req, " right"}, right_addr, r);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    frame_t f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    started = 1;
    @(negedge clk);
    // R1 reset state
    chk(upd_o == 1'b0, "R1 strobe", upd_o, 0);
    expect_state("R1", 0, 0, 0);

    // R9 / R3 back-to-back good frame, M=0xC5
    send_frame(mk(8'hC5), 0);
    expect_state("R9 C5", 1, 40, 0);

    // R11 gaps between bytes, M=0xFA
    send_frame(mk(8'hFA), 2);
    expect_state("R11 FA", 2, 16, 56);

    // R8 bit7 clear and bit6 clear
    send_frame(mk(8'h7A), 0);
    expect_state("R8 7A", 2, 16, 56);
    send_frame(mk(8'hBF), 1);
    expect_state("R8 BF", 2, 16, 56);

    // R4 wrong inverse of payload
    f = mk(8'hC1); f[6] = 8'h00;
    send_frame(f, 0);
    expect_state("R4", 2, 16, 56);

    // R5 wrong sum
    f = mk(8'hC1); f[7] = f[7] + 8'd1;
    send_frame(f, 0);
    expect_state("R5", 2, 16, 56);

    // R6 wrong inverse sum
    f = mk(8'hC1); f[8] = f[7];
    send_frame(f, 0);
    expect_state("R6", 2, 16, 56);

    // R3 header bytes swapped
    f = mk(8'hC1); f[1] = 8'h00; f[2] = 8'hFF;
    send_frame(f, 0);
    expect_state("R3", 2, 16, 56);

    // R7 failing byte is 0x55: must not restart a frame
    send_byte(8'h55, 0);
    send_frame(mk(8'hC1), 0);
    expect_state("R7 no restart", 2, 16, 56);
    // R7 recovery: next clean frame accepted, M=0xD3
    send_frame(mk(8'hD3), 0);
    expect_state("R7 recover", 3, 24, 16);

    // R10 addresses hold over idle time
    repeat (20) @(negedge clk);
    expect_state("R10 hold", 3, 24, 16);

    // mixed gaps, M=0xFF
    send_frame(mk(8'hFF), 3);
    expect_state("R9 FF", 4, 56, 56);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule